// File: doc/BRIEF.md
# Register-Driven Descriptor Queue Bank

This block holds a bank of hardware first-in-first-out queues of 32-bit descriptor words, and every queue is worked through its own 16-byte register window on a simple request/response bus. A producer writes the queue's push/pop register to append a descriptor. A consumer reads that same register to take the oldest descriptor off the queue. Each stored word combines a descriptor pointer aligned to 16 bytes with a 4-bit hint that tells a fetch engine how many 16-byte units to prefetch. The block never alters the word.

Several requesters, two by default, each drive one bus port. Their accesses can land in the same cycle, even on the same queue. In that case the block applies them one after another in a fixed order, so every access is atomic and ordering holds. A word whose pointer field is zero does not become an entry; writing it empties the queue instead. A read of an empty queue returns zero. Each window also has a read-only entry count, and a sticky overflow flag that records pushes dropped because the queue was full.

Top module: `desc_queue_mgr`

## Requirements
- R1: Queue n owns byte addresses n*16 to n*16+15. Within the window, address bits 3:2 choose the register: 0 is the entry count, 1 is overflow status, 2 is reserved and 3 is push/pop. Address bits 1:0 are ignored. The reserved register reads as zero, and writes to it change nothing.
- R2: A write to push/pop whose bits 31:4 are nonzero appends the whole word to the tail of a queue that is not full. Words leave each queue in the order they arrived.
- R3: A read of push/pop on a non-empty queue removes the head entry and returns it unchanged. Bits 31:4 are the pointer and bits 3:0 are the size hint, where value k means (k+1)*16 bytes.
- R4: A read of push/pop on an empty queue returns 32'h0 and leaves the queue unchanged.
- R5: A write to push/pop whose bits 31:4 are zero empties the queue at once, whatever bits 3:0 hold. The written word is not stored.
- R6: A push to a queue that holds DEPTH entries is dropped and sets that queue's overflow flag, which reads as bit 0 of the status register. The flag stays set.
- R7: A write to the status register with bit 0 set clears the flag. A write with bit 0 clear leaves the flag as it was.
- R8: A read of the count register returns, in its low bits, the number of entries held at the start of that cycle, and it removes nothing.
- R9: Read data for a request appears on the same port in the following cycle. That port shows zero after a write or an idle cycle.
- R10: Within one cycle, all reads are served before all writes. Among reads, and among writes, lower-numbered ports go first. So a pop and a push on the same queue in the same cycle return the old head, or zero if the queue was empty, and the pushed word is still stored.
- R11: An access to one queue never changes the entries, count or flag of any other queue.
- R12: After reset, every queue is empty, every overflow flag is clear and every response is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_PORTS | Per-port request strobe |
| req_write | input | NUM_PORTS | Per-port write (1) or read (0) |
| req_addr | input | NUM_PORTS x (log2(NUM_Q)+4) | Per-port byte address |
| req_wdata | input | NUM_PORTS x 32 | Per-port write data |
| rsp_rdata | output | NUM_PORTS x 32 | Per-port read data, one cycle after the request |

## Verification
A pop and a push can reach the same queue in the same cycle, on different ports. The outcome then depends on the serving order: reads first, then writes, each in port order. The bench aims both ports at only four queues, so such collisions happen often in random traffic. It also sets up directed cases: a pop and a push on an empty queue, and a push and a pop on a non-empty queue. A bench model applies the same serving order and predicts each response, and every port is compared against it each cycle.

// File: rtl/dq_pkg.sv
package dq_pkg;

    localparam int WORD_W = 32;

    // register select taken from address bits 3:2
    localparam logic [1:0] SEL_COUNT = 2'd0;
    localparam logic [1:0] SEL_FLAG  = 2'd1;
    localparam logic [1:0] SEL_RSVD  = 2'd2;
    localparam logic [1:0] SEL_DESC  = 2'd3;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_POP,
        OP_PUSH,
        OP_CNT_RD,
        OP_FLAG_RD,
        OP_FLAG_WR
    } op_kind_e;

    function automatic logic is_read_op(op_kind_e k);
        return (k == OP_POP) || (k == OP_CNT_RD) || (k == OP_FLAG_RD);
    endfunction

endpackage

// File: rtl/dq_decode.sv
module dq_decode
    import dq_pkg::*;
#(
    parameter int QIDX_W = 3,
    localparam int ADDR_W = QIDX_W + 4
) (
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    output op_kind_e          kind,
    output logic [QIDX_W-1:0] qidx
);

    logic unused_low_bits;
    assign unused_low_bits = ^addr[1:0];

    always_comb begin
        kind = OP_IDLE;
        qidx = addr[ADDR_W-1:4];
        if (valid) begin
            unique case (addr[3:2])
                SEL_COUNT: kind = write ? OP_IDLE    : OP_CNT_RD;
                SEL_FLAG:  kind = write ? OP_FLAG_WR : OP_FLAG_RD;
                SEL_RSVD:  kind = OP_IDLE;
                SEL_DESC:  kind = write ? OP_PUSH    : OP_POP;
                default:   kind = OP_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dq_store.sv
module dq_store
    import dq_pkg::*;
#(
    parameter int NUM_Q     = 8,
    parameter int DEPTH     = 16,
    parameter int NUM_PORTS = 2,
    localparam int QIDX_W   = $clog2(NUM_Q),
    localparam int PTR_W    = $clog2(DEPTH),
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  op_kind_e                           op_kind [NUM_PORTS],
    input  logic [QIDX_W-1:0]                  op_qidx [NUM_PORTS],
    input  logic [WORD_W-1:0]                  op_data [NUM_PORTS],
    output logic [NUM_PORTS-1:0][WORD_W-1:0]   rdata
);

    typedef struct packed {
        logic [NUM_Q-1:0][DEPTH-1:0][WORD_W-1:0] mem;
        logic [NUM_Q-1:0][PTR_W-1:0]             rd;
        logic [NUM_Q-1:0][PTR_W-1:0]             wr;
        logic [NUM_Q-1:0][CNT_W-1:0]             cnt;
        logic [NUM_Q-1:0]                        ovf;
        logic [NUM_PORTS-1:0][WORD_W-1:0]        rdata;
    } state_t;

    state_t st_d, st_q;

    function automatic logic [PTR_W-1:0] ptr_next(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    // Accesses are applied one at a time: phase 0 serves reads, phase 1
    // serves writes, each in ascending port order.
    always_comb begin
        logic [QIDX_W-1:0] qi;
        st_d       = st_q;
        st_d.rdata = '0;
        qi         = '0;
        for (int ph = 0; ph < 2; ph++) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                qi = op_qidx[p];
                if (op_kind[p] != OP_IDLE && (is_read_op(op_kind[p]) == (ph == 0))) begin
                    case (op_kind[p])
                        OP_POP: begin
                            if (st_d.cnt[qi] != '0) begin
                                st_d.rdata[p] = st_d.mem[qi][st_d.rd[qi]];
                                st_d.rd[qi]   = ptr_next(st_d.rd[qi]);
                                st_d.cnt[qi]  = st_d.cnt[qi] - CNT_W'(1);
                            end
                        end
                        OP_CNT_RD: begin
                            st_d.rdata[p] = WORD_W'(st_q.cnt[qi]);
                        end
                        OP_FLAG_RD: begin
                            st_d.rdata[p] = {{(WORD_W-1){1'b0}}, st_q.ovf[qi]};
                        end
                        OP_PUSH: begin
                            if (op_data[p][WORD_W-1:4] == '0) begin
                                st_d.cnt[qi] = '0;
                                st_d.rd[qi]  = '0;
                                st_d.wr[qi]  = '0;
                            end else if (st_d.cnt[qi] == CNT_W'(DEPTH)) begin
                                st_d.ovf[qi] = 1'b1;
                            end else begin
                                st_d.mem[qi][st_d.wr[qi]] = op_data[p];
                                st_d.wr[qi]  = ptr_next(st_d.wr[qi]);
                                st_d.cnt[qi] = st_d.cnt[qi] + CNT_W'(1);
                            end
                        end
                        OP_FLAG_WR: begin
                            if (op_data[p][0]) begin
                                st_d.ovf[qi] = 1'b0;
                            end
                        end
                        default: begin
                        end
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.rdata;

    // helper vectors for the checks below
    logic [NUM_Q-1:0] q_touched;
    logic [NUM_Q-1:0] q_clear_req;
    always_comb begin
        q_touched   = '0;
        q_clear_req = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (op_kind[p] != OP_IDLE) begin
                q_touched[op_qidx[p]] = 1'b1;
            end
            if (op_kind[p] == OP_FLAG_WR && op_data[p][0]) begin
                q_clear_req[op_qidx[p]] = 1'b1;
            end
        end
    end

    AST_EMPTY_POP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op_kind[0] == OP_POP && st_q.cnt[op_qidx[0]] == '0) |=> (st_q.rdata[0] == '0)); // R4

    for (genvar gi = 0; gi < NUM_Q; gi++) begin : g_qchk
        AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.cnt[gi] <= CNT_W'(DEPTH)); // R6

        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.ovf[gi] && !q_clear_req[gi]) |=> st_q.ovf[gi]); // R7

        AST_QUEUE_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
            !q_touched[gi] |=> ($stable(st_q.cnt[gi]) && $stable(st_q.ovf[gi]))); // R11

        AST_FLUSH_LAST: assert property (@(posedge clk) disable iff (!rst_n)
            (op_kind[NUM_PORTS-1] == OP_PUSH && op_qidx[NUM_PORTS-1] == QIDX_W'(gi)
             && op_data[NUM_PORTS-1][WORD_W-1:4] == '0) |=> (st_q.cnt[gi] == '0)); // R5
    end

endmodule

// File: rtl/desc_queue_mgr.sv
module desc_queue_mgr
    import dq_pkg::*;
#(
    parameter int NUM_Q     = 8,
    parameter int DEPTH     = 16,
    parameter int NUM_PORTS = 2,
    localparam int QIDX_W   = $clog2(NUM_Q),
    localparam int ADDR_W   = QIDX_W + 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_PORTS-1:0]               req_valid,
    input  logic [NUM_PORTS-1:0]               req_write,
    input  logic [NUM_PORTS-1:0][ADDR_W-1:0]   req_addr,
    input  logic [NUM_PORTS-1:0][WORD_W-1:0]   req_wdata,
    output logic [NUM_PORTS-1:0][WORD_W-1:0]   rsp_rdata
);

    op_kind_e          dec_kind [NUM_PORTS];
    logic [QIDX_W-1:0] dec_qidx [NUM_PORTS];
    logic [WORD_W-1:0] dec_data [NUM_PORTS];

    for (genvar gp = 0; gp < NUM_PORTS; gp++) begin : g_port
        dq_decode #(
            .QIDX_W (QIDX_W)
        ) dec_i (
            .valid (req_valid[gp]),
            .write (req_write[gp]),
            .addr  (req_addr[gp]),
            .kind  (dec_kind[gp]),
            .qidx  (dec_qidx[gp])
        );
        assign dec_data[gp] = req_wdata[gp];

        AST_IDLE_RSP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (!req_valid[gp] || req_write[gp]) |=> (rsp_rdata[gp] == '0)); // R9
    end

    dq_store #(
        .NUM_Q     (NUM_Q),
        .DEPTH     (DEPTH),
        .NUM_PORTS (NUM_PORTS)
    ) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_kind (dec_kind),
        .op_qidx (dec_qidx),
        .op_data (dec_data),
        .rdata   (rsp_rdata)
    );

endmodule

// File: tb/desc_queue_mgr_tb.sv
`timescale 1ns/1ps
module desc_queue_mgr_tb_top;

    localparam int NQ  = 8;
    localparam int DEP = 16;
    localparam int NP  = 2;
    localparam int AW  = 7;

    logic                   clk = 1'b0;
    logic                   rst_n;
    logic [NP-1:0]          req_valid;
    logic [NP-1:0]          req_write;
    logic [NP-1:0][AW-1:0]  req_addr;
    logic [NP-1:0][31:0]    req_wdata;
    logic [NP-1:0][31:0]    rsp_rdata;

    always #2.5 clk = ~clk;

    desc_queue_mgr dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_rdata (rsp_rdata)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // bench model of the queues
    logic [31:0] m_mem [NQ][DEP];
    int          m_head [NQ];
    int          m_cnt  [NQ];
    bit          m_ovf  [NQ];
    logic [31:0] last_rsp [NP];

    function automatic logic [AW-1:0] ad(int q, int ofs);
        return AW'(q * 16 + ofs);
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
        end
    endtask

    task automatic run_cycle(bit v0, bit w0, logic [AW-1:0] a0, logic [31:0] d0,
                             bit v1, bit w1, logic [AW-1:0] a1, logic [31:0] d1);
        bit          v [NP];
        bit          w [NP];
        logic [AW-1:0] a [NP];
        logic [31:0] d [NP];
        logic [31:0] exp [NP];
        string       tag [NP];
        int          c0 [NQ];
        bit          f0 [NQ];
        v[0] = v0; w[0] = w0; a[0] = a0; d[0] = d0;
        v[1] = v1; w[1] = w1; a[1] = a1; d[1] = d1;
        for (int q = 0; q < NQ; q++) begin
            c0[q] = m_cnt[q];
            f0[q] = m_ovf[q];
        end
        for (int p = 0; p < NP; p++) begin
            exp[p] = 32'h0;
            tag[p] = "R9";
        end
        // R10: reads in port order, then writes in port order
        for (int ph = 0; ph < 2; ph++) begin
            for (int p = 0; p < NP; p++) begin
                int q;
                int sel;
                q   = int'(a[p][6:4]);
                sel = int'(a[p][3:2]);
                if (v[p] && ph == 0 && !w[p]) begin
                    case (sel)
                        0: begin exp[p] = 32'(c0[q]); tag[p] = "R8"; end
                        1: begin exp[p] = {31'd0, f0[q]}; tag[p] = "R6"; end
                        2: begin exp[p] = 32'h0; tag[p] = "R1"; end
                        default: begin
                            if (m_cnt[q] == 0) begin
                                exp[p] = 32'h0; tag[p] = "R4";
                            end else begin
                                exp[p] = m_mem[q][m_head[q]];
                                m_head[q] = (m_head[q] + 1) % DEP;
                                m_cnt[q]--;
                                tag[p] = "R3";
                            end
                        end
                    endcase
                end
                if (v[p] && ph == 1 && w[p]) begin
                    if (sel == 1) begin
                        if (d[p][0]) m_ovf[q] = 1'b0;
                    end else if (sel == 3) begin
                        if (d[p][31:4] == 28'h0) begin
                            m_cnt[q] = 0;
                            m_head[q] = 0;
                        end else if (m_cnt[q] == DEP) begin
                            m_ovf[q] = 1'b1;
                        end else begin
                            m_mem[q][(m_head[q] + m_cnt[q]) % DEP] = d[p];
                            m_cnt[q]++;
                        end
                    end
                end
            end
        end
        for (int p = 0; p < NP; p++) begin
            req_valid[p] = v[p];
            req_write[p] = w[p];
            req_addr[p]  = a[p];
            req_wdata[p] = d[p];
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = '0;
        for (int p = 0; p < NP; p++) begin
            last_rsp[p] = rsp_rdata[p];
            check(tag[p], rsp_rdata[p], exp[p]);
        end
    endtask

    task automatic push(int q, logic [31:0] d);
        run_cycle(1, 1, ad(q, 12), d, 0, 0, '0, '0);
    endtask

    task automatic rd0(int q, int ofs);
        run_cycle(1, 0, ad(q, ofs), '0, 0, 0, '0, '0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R9 watchdog got=hung exp=finished");
        finish_run();
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EED_0042);
        for (int q = 0; q < NQ; q++) begin
            m_head[q] = 0; m_cnt[q] = 0; m_ovf[q] = 0;
        end
        rst_n     = 1'b0;
        req_valid = '0;
        req_write = '0;
        req_addr  = '0;
        req_wdata = '0;
        repeat (3) @(negedge clk);
        check("R12", rsp_rdata[0], 32'h0);
        rst_n = 1'b1;

        // R12: empty, flag clear after reset
        rd0(0, 0);  check("R12", last_rsp[0], 32'h0);
        rd0(4, 4);  check("R12", last_rsp[0], 32'h0);
        rd0(3, 12); check("R12", last_rsp[0], 32'h0);

        // R2, R3: ordering and pass-through of the size hint
        push(1, 32'hA000_0013);
        push(1, 32'hB000_0025);
        push(1, 32'hC000_00FF);
        rd0(1, 12); check("R2", last_rsp[0], 32'hA000_0013);
        rd0(1, 12); check("R2", last_rsp[0], 32'hB000_0025);
        rd0(1, 12); check("R3", last_rsp[0], 32'hC000_00FF);
        rd0(1, 12); check("R4", last_rsp[0], 32'h0);

        // R6: fill queue 2, then one more
        for (int k = 0; k < DEP; k++) push(2, 32'h1000_0000 + 32'(k * 16 + k));
        push(2, 32'hDEAD_BEE0);
        rd0(2, 4);  check("R6", last_rsp[0], 32'h1);
        rd0(2, 0);  check("R8", last_rsp[0], 32'(DEP));
        rd0(2, 12); check("R6", last_rsp[0], 32'h1000_0000);

        // R7: clear only with bit 0 set
        run_cycle(1, 1, ad(2, 4), 32'hFFFF_FFFE, 0, 0, '0, '0);
        rd0(2, 4);  check("R7", last_rsp[0], 32'h1);
        run_cycle(1, 1, ad(2, 4), 32'h0000_0001, 0, 0, '0, '0);
        rd0(2, 4);  check("R7", last_rsp[0], 32'h0);

        // R5: zero pointer flushes regardless of size bits
        push(2, 32'h0000_000F);
        rd0(2, 0);  check("R5", last_rsp[0], 32'h0);
        rd0(2, 12); check("R5", last_rsp[0], 32'h0);

        // R10: same-cycle pop and push on one queue
        run_cycle(1, 0, ad(5, 12), '0, 1, 1, ad(5, 12), 32'h5550_0001);
        check("R10", last_rsp[0], 32'h0);
        rd0(5, 0);  check("R10", last_rsp[0], 32'h1);
        push(5, 32'h6660_0002);
        run_cycle(1, 1, ad(5, 12), 32'h7770_0003, 1, 0, ad(5, 12), '0);
        check("R10", last_rsp[1], 32'h5550_0001);
        rd0(5, 12); check("R10", last_rsp[0], 32'h6660_0002);
        rd0(5, 12); check("R10", last_rsp[0], 32'h7770_0003);

        // R11: other queues untouched
        push(6, 32'h6000_0040);
        rd0(7, 0);  check("R11", last_rsp[0], 32'h0);
        rd0(6, 0);  check("R11", last_rsp[0], 32'h1);

        // R1: reserved register and ignored low address bits
        rd0(0, 8);  check("R1", last_rsp[0], 32'h0);
        run_cycle(1, 1, ad(3, 8), 32'hFFFF_FFF0, 0, 0, '0, '0);
        rd0(3, 0);  check("R1", last_rsp[0], 32'h0);
        run_cycle(1, 1, ad(3, 15), 32'h3300_0007, 0, 0, '0, '0);
        rd0(3, 0);  check("R1", last_rsp[0], 32'h1);

        // random traffic on four queues to provoke collisions (R10)
        for (int i = 0; i < 4000; i++) begin
            bit          v [NP];
            bit          w [NP];
            logic [AW-1:0] a [NP];
            logic [31:0] d [NP];
            int          wpct;
            case ((i / 200) % 3)
                0: wpct = 70;
                1: wpct = 30;
                default: wpct = 50;
            endcase
            for (int p = 0; p < NP; p++) begin
                int r;
                int ofs;
                v[p] = ($urandom % 4) != 0;
                w[p] = int'($urandom % 100) < wpct;
                r = int'($urandom % 16);
                ofs = (r < 9) ? 12 : (r < 12) ? 0 : (r < 15) ? 4 : 8;
                a[p] = ad(int'($urandom % 4), ofs);
                d[p] = $urandom;
                if (($urandom % 20) == 0) d[p][31:4] = 28'h0;
            end
            run_cycle(v[0], w[0], a[0], d[0], v[1], w[1], a[1], d[1]);
        end

        finish_run();
    end

endmodule